// File: doc/BRIEF.md
# Dual Event Counter Monitor

This block counts hardware events on two 32-bit counters. Every cycle it receives a vector of event strobes and the current privilege context of the processor. Each counter has its own event selector, which picks one strobe by code. All counting is gated by one shared set of user, supervisor and hypervisor enables. A counter can therefore not be switched off on its own. To keep one counter still while the other runs, software points it at a rarely firing event: code 0x1C on the upper counter or code 0x14 on the lower counter.

Software reaches three registers through a synchronous register port. The control register holds the two selectors, the context enables and an interrupt enable. The counter register holds both counters side by side, so one write replaces both. The overflow status register holds one sticky flag per counter, set when that counter wraps and cleared by writing one to it. The interrupt output is raised while a flag is set and interrupts are enabled.

Top module: `dual_evt_monitor`

## Requirements
- R1: After reset, the control, counter and overflow status registers read zero and `irq_out` is low.
- R2: Address 1 reads as {upper counter, lower counter}, with the upper counter in bits 63:32. A write to address 1 replaces both counters at the clock edge.
- R3: Control register at address 0: bit 0 interrupt enable, bit 1 supervisor enable, bit 2 user enable, bit 3 hypervisor enable, bits 9:4 lower event select, bits 16:11 upper event select. Every other bit reads zero.
- R4: A counter steps by exactly one in a cycle when the strobe indexed by its event select is high and the enable for the current `priv_ctx` is set. `priv_ctx` encodes 0 user, 1 supervisor, 2 hypervisor and 3 none; none never counts.
- R5: The context enables are shared: a context whose enable is clear counts on neither counter, and with all three enables clear neither counter moves.
- R6: Each counter follows only its own selected strobe. Strobe 0x00 is cycles, 0x01 retired instructions and 0x09 cache misses on the upper counter or cache references on the lower. With the parked codes (0x1C upper, 0x14 lower) and that strobe low, the counter stays put.
- R7: Stepping from 0xFFFFFFFF to 0 sets that counter's sticky flag in the overflow status register at address 2: bit 1 is the upper counter and bit 0 the lower. No other step sets a flag.
- R8: Writing address 2 clears every flag written as one and leaves the others. A wrap in the same cycle as the clear keeps the flag set.
- R9: `irq_out` is high exactly when a flag is set and the interrupt enable is one. Clearing the enable drops `irq_out` and leaves the flags unchanged.
- R10: A counter write in the same cycle as a counted event loads the written value and flags no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 counters, 2 overflow status |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data of the selected register (combinational) |
| evt_strobe | input | 64 | Event strobes indexed by event code |
| priv_ctx | input | 2 | Current privilege context |
| irq_out | output | 1 | Overflow interrupt |

## Verification
A table drives the counting path. It pairs the enable sets with privilege contexts that match them, contexts that do not, the context with no enable, and all enables clear. It also pairs selectors with strobe patterns that light both selected events, only one of them, or only the parked codes. This separates context gating from event selection, and one counter's selection from the other's. Directed sequences then step a counter up to the wrap and check that the flag is clear one step before it and set on it. They also cover a write-one-to-clear on the wrong bit, a clear in the same cycle as a wrap, and a counter write that collides with a counted event at all-ones.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  localparam int IRQ_EN_BIT = 0;
  localparam int SUP_EN_BIT = 1;
  localparam int USR_EN_BIT = 2;
  localparam int HV_EN_BIT  = 3;
  localparam int LO_SEL_LSB = 4;
  localparam int UP_SEL_LSB = 11;

  localparam logic [5:0] PARK_CODE_UP = 6'h1C;
  localparam logic [5:0] PARK_CODE_LO = 6'h14;

  typedef enum logic [1:0] {
    CTX_USER = 2'd0,
    CTX_SUP  = 2'd1,
    CTX_HV   = 2'd2,
    CTX_NONE = 2'd3
  } priv_ctx_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_OVF  = 2'd2
  } reg_addr_e;

  function automatic logic ctx_allowed(input logic [1:0] ctx,
                                       input logic en_usr,
                                       input logic en_sup,
                                       input logic en_hv);
    case (ctx)
      CTX_USER: return en_usr;
      CTX_SUP:  return en_sup;
      CTX_HV:   return en_hv;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evmon_ctrl_reg.sv
module evmon_ctrl_reg #(
  parameter int SEL_W = 6,
  localparam int FIELD_W = evmon_pkg::UP_SEL_LSB + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wdata,
  output logic [FIELD_W-1:0] ctrl_q
);
  import evmon_pkg::*;

  localparam logic [FIELD_W-1:0] SEL_ONES = FIELD_W'({SEL_W{1'b1}});
  localparam logic [FIELD_W-1:0] KEEP_MASK =
      (SEL_ONES << UP_SEL_LSB) | (SEL_ONES << LO_SEL_LSB) | FIELD_W'(4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & KEEP_MASK;
  end

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q[UP_SEL_LSB +: SEL_W] == $past(wdata[UP_SEL_LSB +: SEL_W]));

endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int CTR_W = 32,
  parameter int SEL_W = 6,
  localparam int NUM_EVT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [SEL_W-1:0]   sel,
  input  logic               ctx_ok,
  input  logic               wr,
  input  logic [CTR_W-1:0]   wdata,
  input  logic               clr,
  output logic [CTR_W-1:0]   count,
  output logic               ovf_flag,
  output logic               wrap_evt
);

  function automatic logic [CTR_W:0] bump(input logic [CTR_W-1:0] v);
    return {1'b0, v} + {{CTR_W{1'b0}}, 1'b1};
  endfunction

  logic             hit;
  logic [CTR_W:0]   stepped;

  assign hit      = evt_strobe[sel] && ctx_ok;
  assign stepped  = bump(count);
  assign wrap_evt = hit && !wr && stepped[CTR_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (wr)  count <= wdata;
    else if (hit) count <= stepped[CTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap_evt) ovf_flag <= 1'b1;
    else if (clr)      ovf_flag <= 1'b0;
  end

  // R7
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> count == $past(wdata));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr) |=> count == CTR_W'($past(count) + 1'b1));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_evt && !clr) |=> ovf_flag == $past(ovf_flag));

endmodule

// File: rtl/dual_evt_monitor.sv
module dual_evt_monitor #(
  parameter int CTR_W = 32,
  parameter int SEL_W = 6,
  localparam int NUM_EVT = 1 << SEL_W,
  localparam int BUS_W   = 2 * CTR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [1:0]         bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [1:0]         priv_ctx,
  output logic               irq_out
);
  import evmon_pkg::*;

  localparam int NUM_CTR = 2;
  localparam int FIELD_W = UP_SEL_LSB + SEL_W;

  logic [FIELD_W-1:0] ctrl_q;
  logic               ctx_ok;
  logic               cnt_wr;
  logic               ctrl_wr;
  logic               ovf_wr;
  logic [BUS_W-1:0]   cnt_pair;
  logic [NUM_CTR-1:0] ovf_vec;
  logic [NUM_CTR-1:0] wrap_vec;
  logic [SEL_W-1:0]   sel_arr [NUM_CTR];

  assign ctrl_wr = bus_we && (bus_addr == REG_CTRL);
  assign cnt_wr  = bus_we && (bus_addr == REG_CNT);
  assign ovf_wr  = bus_we && (bus_addr == REG_OVF);

  evmon_ctrl_reg #(.SEL_W(SEL_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (bus_wdata[FIELD_W-1:0]),
    .ctrl_q (ctrl_q)
  );

  assign ctx_ok = ctx_allowed(priv_ctx, ctrl_q[USR_EN_BIT],
                              ctrl_q[SUP_EN_BIT], ctrl_q[HV_EN_BIT]);

  assign sel_arr[0] = ctrl_q[LO_SEL_LSB +: SEL_W];
  assign sel_arr[1] = ctrl_q[UP_SEL_LSB +: SEL_W];

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    evmon_counter #(.CTR_W(CTR_W), .SEL_W(SEL_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_strobe (evt_strobe),
      .sel        (sel_arr[g]),
      .ctx_ok     (ctx_ok),
      .wr         (cnt_wr),
      .wdata      (bus_wdata[g*CTR_W +: CTR_W]),
      .clr        (ovf_wr && bus_wdata[g]),
      .count      (cnt_pair[g*CTR_W +: CTR_W]),
      .ovf_flag   (ovf_vec[g]),
      .wrap_evt   (wrap_vec[g])
    );
  end

  assign irq_out = (|ovf_vec) && ctrl_q[IRQ_EN_BIT];

  always_comb begin
    case (bus_addr)
      REG_CTRL: bus_rdata = BUS_W'(ctrl_q);
      REG_CNT:  bus_rdata = cnt_pair;
      REG_OVF:  bus_rdata = BUS_W'(ovf_vec);
      default:  bus_rdata = '0;
    endcase
  end

  // R5
  idle_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_ok && !cnt_wr) |=> $stable(cnt_pair));

  // R7
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec == '0) |=> (ovf_vec & ~$past(ovf_vec)) == '0);

endmodule

// File: tb/dual_evt_monitor_tb.sv
module dual_evt_monitor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [63:0] evt_strobe = '0;
  logic [1:0]  priv_ctx = 2'd3;
  logic        irq_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dual_evt_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe),
    .priv_ctx(priv_ctx), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [3:0]  en;   // {hv, usr, sup, irq}
    logic [5:0]  up;
    logic [5:0]  lo;
    logic [1:0]  ctx;
    logic [63:0] stb;
    logic [7:0]  n;
    logic [31:0] exp_up;
    logic [31:0] exp_lo;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{4'b0100, 6'h00, 6'h01, 2'd0, 64'h3,         8'd5, 32'd5, 32'd5}, // R4 user counts
    '{4'b0100, 6'h00, 6'h01, 2'd1, 64'h3,         8'd5, 32'd0, 32'd0}, // R5 sup disabled
    '{4'b0010, 6'h09, 6'h09, 2'd1, 64'h200,       8'd4, 32'd4, 32'd4}, // R6 code 0x09
    '{4'b1000, 6'h1C, 6'h00, 2'd2, 64'h1,         8'd6, 32'd0, 32'd6}, // R6 upper parked
    '{4'b0000, 6'h00, 6'h01, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 32'd0, 32'd0}, // R5 all clear
    '{4'b1110, 6'h00, 6'h01, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, 32'd0, 32'd0}, // R4 ctx none
    '{4'b1110, 6'h05, 6'h14, 2'd2, 64'h20,        8'd7, 32'd7, 32'd0}, // R6 lower parked
    '{4'b0100, 6'h03, 6'h07, 2'd0, 64'h80,        8'd3, 32'd0, 32'd3}  // R6 own select
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [63:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run_strobe(input logic [63:0] s, input logic [1:0] c, input int n);
    @(negedge clk);
    evt_strobe = s; priv_ctx = c;
    repeat (n) @(negedge clk);
    evt_strobe = '0;
  endtask

  function automatic logic [63:0] mk_ctrl(input logic [3:0] en, input logic [5:0] up,
                                          input logic [5:0] lo);
    return 64'(en) | (64'(lo) << 4) | (64'(up) << 11);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); chk("R1 ctrl", rd, 64'h0);
    bus_read(2'd1, rd); chk("R1 counters", rd, 64'h0);
    bus_read(2'd2, rd); chk("R1 status", rd, 64'h0);
    chk("R1 irq", {63'h0, irq_out}, 64'h0);

    // R3 control layout, reserved bits read zero
    bus_write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_read(2'd0, rd); chk("R3 ctrl readback", rd, 64'h1FBFF);

    // R2 counter register both halves
    bus_write(2'd1, 64'hDEAD_BEEF_1234_5678);
    bus_read(2'd1, rd); chk("R2 counter pair", rd, 64'hDEAD_BEEF_1234_5678);

    // table walk: R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      bus_write(2'd1, 64'h0);
      bus_write(2'd0, mk_ctrl(TBL[i].en, TBL[i].up, TBL[i].lo));
      run_strobe(TBL[i].stb, TBL[i].ctx, int'(TBL[i].n));
      bus_read(2'd1, rd);
      chk($sformatf("R4/R5/R6 table row %0d", i), rd, {TBL[i].exp_up, TBL[i].exp_lo});
    end

    // R7 overflow on wrap of the upper counter, lower parked
    bus_write(2'd0, mk_ctrl(4'b0101, 6'h00, 6'h14));
    bus_write(2'd1, 64'hFFFF_FFFE_0000_0000);
    run_strobe(64'h1, 2'd0, 1);
    bus_read(2'd2, rd); chk("R7 no flag before wrap", rd, 64'h0);
    bus_read(2'd1, rd); chk("R7 at all-ones", rd, 64'hFFFF_FFFF_0000_0000);
    run_strobe(64'h1, 2'd0, 1);
    bus_read(2'd1, rd); chk("R7 wrapped to zero", rd, 64'h0);
    bus_read(2'd2, rd); chk("R7 upper flag", rd, 64'h2);
    chk("R9 irq raised", {63'h0, irq_out}, 64'h1);

    // R9 interrupt enable cleared hides irq, flag stays
    bus_write(2'd0, mk_ctrl(4'b0100, 6'h00, 6'h14));
    chk("R9 irq masked", {63'h0, irq_out}, 64'h0);
    bus_read(2'd2, rd); chk("R9 flag kept", rd, 64'h2);

    // R8 write-one-to-clear
    bus_write(2'd2, 64'h1);
    bus_read(2'd2, rd); chk("R8 other bit untouched", rd, 64'h2);
    bus_write(2'd2, 64'h2);
    bus_read(2'd2, rd); chk("R8 cleared", rd, 64'h0);

    // R10 write collides with counted event at all-ones
    bus_write(2'd0, mk_ctrl(4'b0101, 6'h00, 6'h00));
    bus_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    evt_strobe = 64'h1; priv_ctx = 2'd0;
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 64'h0000_0010_0000_0020;
    @(negedge clk);
    evt_strobe = '0; bus_we = 1'b0; bus_wdata = '0;
    bus_read(2'd1, rd); chk("R10 write wins", rd, 64'h0000_0010_0000_0020);
    bus_read(2'd2, rd); chk("R10 no overflow", rd, 64'h0);
    chk("R10 irq low", {63'h0, irq_out}, 64'h0);

    // R8 wrap and clear in the same cycle keeps the flag
    bus_write(2'd0, mk_ctrl(4'b0101, 6'h1C, 6'h00));
    bus_write(2'd1, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk);
    evt_strobe = 64'h1; priv_ctx = 2'd0;
    bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 64'h1;
    @(negedge clk);
    evt_strobe = '0; bus_we = 1'b0; bus_wdata = '0;
    bus_read(2'd2, rd); chk("R8 set beats clear", rd, 64'h1);
    chk("R9 irq from lower", {63'h0, irq_out}, 64'h1);

    finish_run();
  end

endmodule